// File: doc/BRIEF.md
# Scan Checkpoint Rollback Controller

This block supervises two identical processing units that run in lock-step as a master and a checker. Each unit has a serial scan chain over its internal state and a result bus. The controller compares the two result buses on every cycle. At a fixed period it freezes both units and shifts the master's state out through its scan chain into an on-chip checkpoint store. Each chain's output is fed back to its own input during this shift, so after a full pass both units hold what they held before.

When the result buses differ, the controller freezes both units. It shifts the last committed checkpoint into both chains at the same time and then lets the units run again. A checkpoint is committed only when its capture shift finishes with no disagreement. Until then the older copy stays valid, because the store has two banks and a pointer to the good one.

Some disagreements cannot be repaired. One is a disagreement that comes before any checkpoint exists. Another is a second disagreement that comes too soon after a rollback, which points to a lasting fault. In either case the controller halts the pair for good until reset.

Top module: `scan_rollback_ctrl`

## Requirements
- R1: After reset the block is in the run state: state_code is 0, halted is 0, rollback_cnt is 0, unit_clk_en is 1 and scan_en is 0.
- R2: After CKPT_INTERVAL run cycles with no disagreement, the block enters capture (state_code 1). Capture lasts CHAIN_LEN cycles with scan_en at 1 and unit_clk_en at 0.
- R3: During capture each unit's scan input equals its own scan output. Both units therefore hold unchanged state once capture ends.
- R4: When the buses differ while a committed checkpoint exists, the block enters restore (state_code 2) for CHAIN_LEN+1 cycles. unit_clk_en is 0 throughout, and scan_en is 1 for the last CHAIN_LEN of those cycles. Both chains receive the stored bits in the order they were captured, so both units end up holding the master's state as it was at the start of the last committed capture. The block then returns to run.
- R5: A disagreement during capture drops the partial copy. The rollback that follows restores the previously committed checkpoint.
- R6: A disagreement before any checkpoint has been committed moves the block to the halt state (state_code 3) with halted at 1.
- R7: A disagreement within PERM_WINDOW cycles after a restore completes moves the block to halt. A disagreement after that window leads to another rollback.
- R8: Halt is kept until reset, with unit_clk_en and scan_en both 0.
- R9: rollback_cnt rises by exactly one for each completed restore and saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_out | input | OUT_W | Master result bus |
| c_out | input | OUT_W | Checker result bus |
| m_scan_out | input | 1 | Master scan chain output |
| c_scan_out | input | 1 | Checker scan chain output |
| unit_clk_en | output | 1 | Clock enable for both units (run state only) |
| scan_en | output | 1 | Shift enable for both scan chains |
| m_scan_in | output | 1 | Master scan chain input |
| c_scan_in | output | 1 | Checker scan chain input |
| state_code | output | 2 | 0 run, 1 capture, 2 restore, 3 halt |
| rollback_cnt | output | CNT_W | Completed rollbacks, saturating |
| halted | output | 1 | Unrecoverable fault, held until reset |

## Verification
The bench builds the block with a 16-bit chain, an 8-bit result bus, a checkpoint every 40 run cycles, a 20-cycle window for lasting faults and a 3-bit rollback counter. The short interval gives many captures per run, so faults land in run cycles, inside capture shifts and right at capture boundaries. The short window lets the bench place a second fault both inside and outside it. With the narrow counter, eleven rollbacks are enough to reach saturation. Bench models of the two units make the restored chain contents visible, and the bench compares them with its own snapshots of the master state.

// File: rtl/scp_pkg.sv
package scp_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_CAPTURE = 2'd1,
    ST_RESTORE = 2'd2,
    ST_HALT    = 2'd3
  } scp_state_e;
endpackage

// File: rtl/scp_cmp.sv
module scp_cmp #(
  parameter int OUT_W = 32
) (
  input  logic [OUT_W-1:0] a,
  input  logic [OUT_W-1:0] b,
  output logic             differ
);
  logic [OUT_W-1:0] lane_diff;

  for (genvar i = 0; i < OUT_W; i++) begin : g_lane
    assign lane_diff[i] = a[i] ^ b[i];
  end

  assign differ = |lane_diff;
endmodule

// File: rtl/scp_ckpt_mem.sv
module scp_ckpt_mem #(
  parameter int DEPTH = 256,
  localparam int A_W  = $clog2(DEPTH),
  localparam int M_AW = $clog2(2 * DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic           wbank,
  input  logic [A_W-1:0] waddr,
  input  logic           wdata,
  input  logic           rbank,
  input  logic [A_W-1:0] raddr,
  output logic           rdata
);
  localparam logic [M_AW-1:0] BANK_OFS = M_AW'(DEPTH);

  logic            store [2*DEPTH];
  logic [M_AW-1:0] w_full;
  logic [M_AW-1:0] r_full;

  assign w_full = (wbank ? BANK_OFS : '0) + M_AW'(waddr);
  assign r_full = (rbank ? BANK_OFS : '0) + M_AW'(raddr);

  always_ff @(posedge clk) begin
    if (we) store[w_full] <= wdata;
    rdata <= store[r_full];
  end
endmodule

// File: rtl/scp_scan_route.sv
module scp_scan_route
  import scp_pkg::*;
(
  input  scp_state_e st,
  input  logic [1:0] chain_so,
  input  logic       rd_bit,
  output logic [1:0] chain_si
);
  for (genvar u = 0; u < 2; u++) begin : g_unit
    assign chain_si[u] = (st == ST_CAPTURE) ? chain_so[u] :
                         (st == ST_RESTORE) ? rd_bit : 1'b0;
  end
endmodule

// File: rtl/scp_ctrl.sv
module scp_ctrl
  import scp_pkg::*;
#(
  parameter int CHAIN_LEN     = 256,
  parameter int CKPT_INTERVAL = 4096,
  parameter int PERM_WINDOW   = 1024,
  parameter int CNT_W         = 8,
  localparam int A_W          = $clog2(CHAIN_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mismatch,
  output scp_state_e       st,
  output logic [CNT_W-1:0] rb_cnt,
  output logic             scan_en,
  output logic             clk_en,
  output logic             mem_we,
  output logic             mem_wbank,
  output logic [A_W-1:0]   mem_waddr,
  output logic             mem_rbank,
  output logic [A_W-1:0]   mem_raddr
);
  localparam int IDX_W = $clog2(CHAIN_LEN + 1);
  localparam int RUN_W = $clog2(CKPT_INTERVAL + 1);
  localparam int WIN_W = $clog2(PERM_WINDOW + 1);
  localparam logic [IDX_W-1:0] CAP_LAST = IDX_W'(CHAIN_LEN - 1);
  localparam logic [IDX_W-1:0] RES_LAST = IDX_W'(CHAIN_LEN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(CKPT_INTERVAL - 1);
  localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(PERM_WINDOW);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [IDX_W-1:0] idx;
  logic [RUN_W-1:0] run_cnt;
  logic [WIN_W-1:0] win_cnt;
  logic             ckpt_valid;
  logic             good_bank;
  logic             recover_ok;

  assign recover_ok = ckpt_valid && (win_cnt == '0);

  assign clk_en    = (st == ST_RUN);
  assign scan_en   = (st == ST_CAPTURE) || (st == ST_RESTORE && idx != '0);
  assign mem_we    = (st == ST_CAPTURE);
  assign mem_wbank = ~good_bank;
  assign mem_waddr = A_W'(idx);
  assign mem_rbank = good_bank;
  assign mem_raddr = (idx == RES_LAST) ? '0 : A_W'(idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_RUN;
      idx        <= '0;
      run_cnt    <= '0;
      win_cnt    <= '0;
      ckpt_valid <= 1'b0;
      good_bank  <= 1'b1;
      rb_cnt     <= '0;
    end else begin
      if (win_cnt != '0 && st != ST_HALT) win_cnt <= win_cnt - 1'b1;
      case (st)
        ST_RUN: begin
          if (mismatch) begin
            st  <= recover_ok ? ST_RESTORE : ST_HALT;
            idx <= '0;
          end else if (run_cnt == RUN_LAST) begin
            st      <= ST_CAPTURE;
            idx     <= '0;
            run_cnt <= '0;
          end else begin
            run_cnt <= run_cnt + 1'b1;
          end
        end
        ST_CAPTURE: begin
          if (mismatch) begin
            st  <= recover_ok ? ST_RESTORE : ST_HALT;
            idx <= '0;
          end else if (idx == CAP_LAST) begin
            st         <= ST_RUN;
            idx        <= '0;
            run_cnt    <= '0;
            ckpt_valid <= 1'b1;
            good_bank  <= ~good_bank;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_RESTORE: begin
          if (idx == RES_LAST) begin
            st      <= ST_RUN;
            idx     <= '0;
            run_cnt <= '0;
            win_cnt <= WIN_LOAD;
            if (rb_cnt != CNT_MAX) rb_cnt <= rb_cnt + 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= ST_HALT;
      endcase
    end
  end

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    st == ST_HALT |=> st == ST_HALT);

  // R9
  rb_step_chk: assert property (@(posedge clk) disable iff (rst)
    rb_cnt != $past(rb_cnt) |-> rb_cnt == $past(rb_cnt) + 1'b1);

  // R6
  restore_needs_ckpt_chk: assert property (@(posedge clk) disable iff (rst)
    st == ST_RESTORE |-> ckpt_valid);

  // R2
  capture_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CAPTURE && $past(st) != ST_CAPTURE) |->
      ($past(st) == ST_RUN && $past(run_cnt) == RUN_LAST));

  // R7
  window_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && win_cnt != '0 && mismatch) |=> st == ST_HALT);
endmodule

// File: rtl/scan_rollback_ctrl.sv
module scan_rollback_ctrl
  import scp_pkg::*;
#(
  parameter int CHAIN_LEN     = 256,
  parameter int OUT_W         = 32,
  parameter int CKPT_INTERVAL = 4096,
  parameter int PERM_WINDOW   = 1024,
  parameter int CNT_W         = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OUT_W-1:0] m_out,
  input  logic [OUT_W-1:0] c_out,
  input  logic             m_scan_out,
  input  logic             c_scan_out,
  output logic             unit_clk_en,
  output logic             scan_en,
  output logic             m_scan_in,
  output logic             c_scan_in,
  output logic [1:0]       state_code,
  output logic [CNT_W-1:0] rollback_cnt,
  output logic             halted
);
  localparam int A_W = $clog2(CHAIN_LEN);

  scp_state_e     st;
  logic           mismatch;
  logic           mem_we, mem_wbank, mem_rbank, rd_bit;
  logic [A_W-1:0] mem_waddr, mem_raddr;
  logic [1:0]     chain_si;

  scp_cmp #(.OUT_W(OUT_W)) u_cmp (
    .a(m_out), .b(c_out), .differ(mismatch)
  );

  scp_ctrl #(
    .CHAIN_LEN(CHAIN_LEN), .CKPT_INTERVAL(CKPT_INTERVAL),
    .PERM_WINDOW(PERM_WINDOW), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .mismatch(mismatch), .st(st),
    .rb_cnt(rollback_cnt), .scan_en(scan_en), .clk_en(unit_clk_en),
    .mem_we(mem_we), .mem_wbank(mem_wbank), .mem_waddr(mem_waddr),
    .mem_rbank(mem_rbank), .mem_raddr(mem_raddr)
  );

  scp_ckpt_mem #(.DEPTH(CHAIN_LEN)) u_mem (
    .clk(clk), .we(mem_we), .wbank(mem_wbank), .waddr(mem_waddr),
    .wdata(m_scan_out), .rbank(mem_rbank), .raddr(mem_raddr), .rdata(rd_bit)
  );

  scp_scan_route u_route (
    .st(st), .chain_so({c_scan_out, m_scan_out}), .rd_bit(rd_bit),
    .chain_si(chain_si)
  );

  assign m_scan_in  = chain_si[0];
  assign c_scan_in  = chain_si[1];
  assign state_code = st;
  assign halted     = (st == ST_HALT);
endmodule

// File: tb/scan_rollback_ctrl_test.sv
module scan_rollback_ctrl_test;
  localparam int LEN = 16, OW = 8, IV = 40, PW = 20, CW = 3;
  localparam logic [LEN-1:0] SEED = 16'h1234;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic [LEN-1:0] m_s, c_s;
  logic [LEN-1:0] m_flip = '0, c_flip = '0;
  logic [OW-1:0]  m_out, c_out;
  logic           clk_en, scan_en, m_si, c_si, halted;
  logic [1:0]     sc;
  logic [CW-1:0]  rb;
  int total = 0, bad = 0;

  assign m_out = m_s[OW-1:0] ^ m_s[LEN-1:LEN-OW];
  assign c_out = c_s[OW-1:0] ^ c_s[LEN-1:LEN-OW];

  scan_rollback_ctrl #(
    .CHAIN_LEN(LEN), .OUT_W(OW), .CKPT_INTERVAL(IV),
    .PERM_WINDOW(PW), .CNT_W(CW)
  ) uut (
    .clk(clk), .rst(rst), .m_out(m_out), .c_out(c_out),
    .m_scan_out(m_s[LEN-1]), .c_scan_out(c_s[LEN-1]),
    .unit_clk_en(clk_en), .scan_en(scan_en), .m_scan_in(m_si),
    .c_scan_in(c_si), .state_code(sc), .rollback_cnt(rb), .halted(halted)
  );

  function automatic logic [LEN-1:0] step(input logic [LEN-1:0] s);
    return {s[LEN-2:0], s[LEN-1]} + 1'b1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s <= SEED;
      c_s <= SEED;
    end else begin
      if (scan_en)     m_s <= {m_s[LEN-2:0], m_si} ^ m_flip;
      else if (clk_en) m_s <= step(m_s) ^ m_flip;
      else             m_s <= m_s ^ m_flip;
      if (scan_en)     c_s <= {c_s[LEN-2:0], c_si} ^ c_flip;
      else if (clk_en) c_s <= step(c_s) ^ c_flip;
      else             c_s <= c_s ^ c_flip;
    end
  end

  // tracks the last committed checkpoint from observed state codes
  logic [LEN-1:0] pend, good;
  logic [1:0]     prev_sc = 2'd0;
  always @(negedge clk) begin
    if (rst) prev_sc = 2'd0;
    else begin
      if (prev_sc != 2'd1 && sc == 2'd1) pend = m_s;
      if (prev_sc == 2'd1 && sc == 2'd0) good = pend;
      prev_sc = sc;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_sc(input logic [1:0] code, input int lim, input string req);
    for (int n = 0; n < lim && sc != code; n++) @(negedge clk);
    check(req, 32'(sc), 32'(code));
  endtask

  task automatic inject(input bit on_c, input int b);
    @(negedge clk);
    if (on_c) c_flip = LEN'(1) << b; else m_flip = LEN'(1) << b;
    @(negedge clk);
    m_flip = '0;
    c_flip = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [LEN-1:0] snap, snap1;
    int n, k, s;
    void'($urandom(32'h1ac3));

    // R1 reset state
    do_reset();
    check("R1 state", 32'(sc), 0);
    check("R1 halted", 32'(halted), 0);
    check("R1 count", 32'(rb), 0);
    check("R1 clk_en", 32'(clk_en), 1);
    check("R1 scan_en", 32'(scan_en), 0);

    // R6 fault before any checkpoint
    repeat (5) @(negedge clk);
    inject(1'b1, 0);
    wait_sc(2'd3, 10, "R6 halt");
    check("R6 halted", 32'(halted), 1);
    // R8 halt sticks
    repeat (30) @(negedge clk);
    check("R8 state", 32'(sc), 3);
    check("R8 clk_en", 32'(clk_en), 0);
    check("R8 scan_en", 32'(scan_en), 0);

    // R2 interval and capture length, R3 loop-back
    do_reset();
    n = 0;
    while (sc == 2'd0 && n < 1000) begin n++; @(negedge clk); end
    check("R2 interval", 32'(n), IV);
    snap = m_s;
    k = 0; s = 0;
    while (sc == 2'd1 && k < 1000) begin
      if (scan_en && !clk_en) s++;
      k++; @(negedge clk);
    end
    check("R2 capture len", 32'(k), LEN);
    check("R2 shift en", 32'(s), LEN);
    check("R3 master kept", 32'(m_s), 32'(snap));
    check("R3 checker kept", 32'(c_s), 32'(snap));

    // R4 rollback with length and contents, R9 count
    repeat (6) @(negedge clk);
    inject(1'b0, 5);
    wait_sc(2'd2, 10, "R4 enter");
    k = 0; s = 0;
    while (sc == 2'd2 && k < 1000) begin
      if (scan_en) s++;
      if (clk_en) s += 100;
      k++; @(negedge clk);
    end
    check("R4 restore len", 32'(k), LEN + 1);
    check("R4 shift en", 32'(s), LEN);
    check("R4 master", 32'(m_s), 32'(snap));
    check("R4 checker", 32'(c_s), 32'(snap));
    check("R9 count one", 32'(rb), 1);

    // R7 second fault inside the window
    repeat (4) @(negedge clk);
    inject(1'b1, 2);
    wait_sc(2'd3, 10, "R7 halt");
    check("R7 halted", 32'(halted), 1);
    check("R7 count", 32'(rb), 1);

    // R5 fault during capture falls back to the older checkpoint
    do_reset();
    wait_sc(2'd1, 100, "R5 first capture");
    snap1 = m_s;
    wait_sc(2'd0, 40, "R5 back to run");
    wait_sc(2'd1, 100, "R5 second capture");
    repeat (2) @(negedge clk);
    inject(1'b1, 7);
    wait_sc(2'd2, 10, "R5 restore");
    wait_sc(2'd0, 40, "R5 resume");
    check("R5 master", 32'(m_s), 32'(snap1));
    check("R5 checker", 32'(c_s), 32'(snap1));
    check("R5 count", 32'(rb), 1);

    // R4 R7 random faults outside the window; R9 saturation
    for (int i = 0; i < 10; i++) begin
      repeat (25 + ($urandom % 60)) @(negedge clk);
      wait_sc(2'd0, 40, "R4 idle");
      inject(1'($urandom % 2), int'($urandom % LEN));
      wait_sc(2'd2, 10, "R7 no halt");
      wait_sc(2'd0, 40, "R4 resume");
      check("R4 rand master", 32'(m_s), 32'(good));
      check("R4 rand checker", 32'(c_s), 32'(good));
      check("R7 rand halted", 32'(halted), 0);
    end
    check("R9 saturate", 32'(rb), 7);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule